// File: doc/BRIEF.md
# Calibration Request Servicer

This block answers the memory PHY while it trains itself. Once enabled, it opens row 0 in bank 0 with an activate command. It then polls the PHY's pending-read flag, pending-write flag and word address at a fixed pacing. Each pending request becomes a column read or column write on the SDRAM command port. The column address is the word address times four. A read-data or write-data enable pulse follows each command after a fixed latency.

Each batch of serviced requests is acknowledged to the PHY with a one-cycle pulse on the matching acknowledge lines, and the PHY drops those flags. When the PHY reports that training is finished, the block closes the open row with a precharge-all and raises `done`. `done` stays high until `start` is released. A new rising `start` runs the sequence again.

All command, address, bank, acknowledge and `done` outputs come straight from flops. Whenever no command is issued, the four command strobes are all high and the address and bank are zero.

Top module: `calreq_servicer`

## Requirements
- R1: After reset, all four command strobes are high, address and bank are zero, and both data enables, both acknowledges and `done` are low. They stay that way while `start` is low.
- R2: `start` seen high in the idle state makes an activate appear for one cycle in the next cycle: strobes cs_n=0, ras_n=0, cas_n=1, we_n=1, with address 0 and bank 0. A request pending from that cycle on gets its command exactly PAUSE_CYC+1 (21) cycles after the activate cycle.
- R3: After each acknowledge cycle, the block waits PAUSE_CYC (20) cycles including that cycle, samples the request flags in the next cycle, and issues the first command one cycle later. A request presented in the acknowledge cycle is therefore answered 21 cycles after it. Each request produces exactly one command.
- R4: A pending read produces cs_n=0, ras_n=1, cas_n=0, we_n=1. The address is the request address shifted left by 2 with the two low bits zero, and the bank is 0. Every command uses bank 0.
- R5: A pending write produces cs_n=0, ras_n=1, cas_n=0, we_n=0, with the same shifted address and bank 0.
- R6: `rddata_en` is high for exactly RD_LEN (1) cycle, starting RD_DELAY (7) cycles after the cycle the read command is visible, and low at all other times.
- R7: `wrdata_en` is high for exactly WR_LEN (1) cycle, starting WR_DELAY (4) cycles after the cycle the write command is visible, and low at all other times.
- R8: If read and write are both pending at a sample, the read comes first and the write follows in the very next cycle. Both use the sampled address.
- R9: One cycle after the last command of a sample, `ack_rd` and `ack_wr` pulse together for one cycle. They carry exactly the flags that sample serviced.
- R10: A sample with no flag set issues no command and no acknowledge. The next sample follows PAUSE_CYC+1 cycles later.
- R11: If calibration-done is high at a sample, no column command and no acknowledge are issued, even with requests pending. A precharge-all (cs_n=0, ras_n=0, cas_n=1, we_n=0, address bit 10 set, other address bits zero, bank 0) appears in the next cycle. `done` rises in the cycle after the precharge.
- R12: `done` stays high while `start` is high. It falls in the cycle after `start` is seen low, and a later `start` produces a fresh activate in the following cycle.
- R13: Any cycle without a command shows all strobes high, address zero and bank zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run enable; a high level in idle starts the sequence |
| phy_cal_done | input | 1 | PHY reports training finished |
| phy_rd_pend | input | 1 | PHY has a pending read request |
| phy_wr_pend | input | 1 | PHY has a pending write request |
| phy_req_addr | input | REQ_AW | Word address of the pending request |
| ack_rd | output | 1 | One-cycle acknowledge of a serviced read |
| ack_wr | output | 1 | One-cycle acknowledge of a serviced write |
| cmd_cs_n | output | 1 | Chip select strobe, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write strobe, active low |
| cmd_addr | output | ROW_W | Command address |
| cmd_bank | output | BANK_W | Command bank |
| rddata_en | output | 1 | Delayed read-data enable |
| wrdata_en | output | 1 | Delayed write-data enable |
| done | output | 1 | Closing precharge issued, sequence finished |

## Verification
Three situations are hard to reach from the ports because they depend on the exact sample cycle: both flags pending at one sample, a sample that finds nothing pending, and calibration-done arriving while a request is still pending.

The bench plays the PHY. It drives each new request in the same cycle the acknowledge appears, so the sample cycle is known exactly. For the empty-sample case it holds the flags low past one sample before raising a read. For the closing case it raises calibration-done together with a read, so it can check both that the precharge appears and that the read is dropped.

A sweep over every request address, with the read-only, write-only and both patterns rotating, covers the address shift and the enable latencies.

// File: rtl/calreq_pkg.sv
package calreq_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } ctl_t;

    localparam ctl_t CTL_IDLE  = 4'b1111;
    localparam ctl_t CTL_ACT   = 4'b0011;
    localparam ctl_t CTL_READ  = 4'b0101;
    localparam ctl_t CTL_WRITE = 4'b0100;
    localparam ctl_t CTL_PRECH = 4'b0010;

    // address bit that selects all banks on a precharge
    localparam int PRECH_ALL_BIT = 10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAUSE,
        ST_SAMPLE,
        ST_COLWR,
        ST_ACKSET,
        ST_PRE,
        ST_FIN
    } st_e;

endpackage

// File: rtl/calreq_en_delay.sv
module calreq_en_delay #(
    parameter int DELAY = 4,
    parameter int LEN   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic en_o
);
    localparam int N = DELAY + LEN - 1;

    logic [N-1:0] sh_d, sh_q;

    generate
        if (N == 1) begin : g_single
            always_comb sh_d = fire_i;
        end else begin : g_chain
            always_comb sh_d = {sh_q[N-2:0], fire_i};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // bit k is visible k+1 cycles after the command cycle
    assign en_o = |sh_q[N-1:DELAY-1];

endmodule

// File: rtl/calreq_seq.sv
module calreq_seq
    import calreq_pkg::*;
#(
    parameter int REQ_AW    = 8,
    parameter int ROW_W     = 13,
    parameter int BANK_W    = 2,
    parameter int PAUSE_CYC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cal_done_i,
    input  logic              req_rd_i,
    input  logic              req_wr_i,
    input  logic [REQ_AW-1:0] req_addr_i,
    output ctl_t              ctl_o,
    output logic [ROW_W-1:0]  addr_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              rd_fire_o,
    output logic              wr_fire_o,
    output logic              ack_rd_o,
    output logic              ack_wr_o,
    output logic              done_o
);
    localparam int CNT_W = $clog2(PAUSE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PAUSE_CYC - 1);

    typedef struct packed {
        st_e               st;
        logic [CNT_W-1:0]  cnt;
        ctl_t              ctl;
        logic [ROW_W-1:0]  addr;
        logic              rd_fire;
        logic              wr_fire;
        logic              cap_rd;
        logic              cap_wr;
        logic [REQ_AW-1:0] cap_addr;
        logic              ack_rd;
        logic              ack_wr;
        logic              done;
    } seq_s;

    seq_s s_d, s_q;

    function automatic logic [ROW_W-1:0] col_of(input logic [REQ_AW-1:0] w);
        return ROW_W'(w) << 2;
    endfunction

    always_comb begin
        s_d         = s_q;
        s_d.ctl     = CTL_IDLE;
        s_d.addr    = '0;
        s_d.rd_fire = 1'b0;
        s_d.wr_fire = 1'b0;
        s_d.ack_rd  = 1'b0;
        s_d.ack_wr  = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                s_d.done = 1'b0;
                if (start_i) begin
                    s_d.ctl = CTL_ACT;
                    s_d.cnt = CNT_LOAD;
                    s_d.st  = ST_PAUSE;
                end
            end
            ST_PAUSE: begin
                if (s_q.cnt == '0) s_d.st  = ST_SAMPLE;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            ST_SAMPLE: begin
                if (cal_done_i) begin
                    s_d.ctl                 = CTL_PRECH;
                    s_d.addr[PRECH_ALL_BIT] = 1'b1;
                    s_d.st                  = ST_PRE;
                end else begin
                    s_d.cap_rd   = req_rd_i;
                    s_d.cap_wr   = req_wr_i;
                    s_d.cap_addr = req_addr_i;
                    if (req_rd_i) begin
                        s_d.ctl     = CTL_READ;
                        s_d.addr    = col_of(req_addr_i);
                        s_d.rd_fire = 1'b1;
                        s_d.st      = req_wr_i ? ST_COLWR : ST_ACKSET;
                    end else if (req_wr_i) begin
                        s_d.ctl     = CTL_WRITE;
                        s_d.addr    = col_of(req_addr_i);
                        s_d.wr_fire = 1'b1;
                        s_d.st      = ST_ACKSET;
                    end else begin
                        s_d.cnt = CNT_LOAD;
                        s_d.st  = ST_PAUSE;
                    end
                end
            end
            ST_COLWR: begin
                s_d.ctl     = CTL_WRITE;
                s_d.addr    = col_of(s_q.cap_addr);
                s_d.wr_fire = 1'b1;
                s_d.st      = ST_ACKSET;
            end
            ST_ACKSET: begin
                s_d.ack_rd = s_q.cap_rd;
                s_d.ack_wr = s_q.cap_wr;
                s_d.cnt    = CNT_LOAD;
                s_d.st     = ST_PAUSE;
            end
            ST_PRE: begin
                s_d.done = 1'b1;
                s_d.st   = ST_FIN;
            end
            ST_FIN: begin
                if (!start_i) begin
                    s_d.done = 1'b0;
                    s_d.st   = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.st       <= ST_IDLE;
            s_q.ctl      <= CTL_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctl_o     = s_q.ctl;
    assign addr_o    = s_q.addr;
    assign bank_o    = '0;
    assign rd_fire_o = s_q.rd_fire;
    assign wr_fire_o = s_q.wr_fire;
    assign ack_rd_o  = s_q.ack_rd;
    assign ack_wr_o  = s_q.ack_wr;
    assign done_o    = s_q.done;

endmodule

// File: rtl/calreq_servicer.sv
module calreq_servicer
    import calreq_pkg::*;
#(
    parameter int REQ_AW    = 8,
    parameter int ROW_W     = 13,
    parameter int BANK_W    = 2,
    parameter int PAUSE_CYC = 20,
    parameter int RD_DELAY  = 7,
    parameter int RD_LEN    = 1,
    parameter int WR_DELAY  = 4,
    parameter int WR_LEN    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              phy_cal_done,
    input  logic              phy_rd_pend,
    input  logic              phy_wr_pend,
    input  logic [REQ_AW-1:0] phy_req_addr,
    output logic              ack_rd,
    output logic              ack_wr,
    output logic              cmd_cs_n,
    output logic              cmd_ras_n,
    output logic              cmd_cas_n,
    output logic              cmd_we_n,
    output logic [ROW_W-1:0]  cmd_addr,
    output logic [BANK_W-1:0] cmd_bank,
    output logic              rddata_en,
    output logic              wrdata_en,
    output logic              done
);
    ctl_t ctl;
    logic rd_fire, wr_fire;

    calreq_seq #(
        .REQ_AW   (REQ_AW),
        .ROW_W    (ROW_W),
        .BANK_W   (BANK_W),
        .PAUSE_CYC(PAUSE_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .cal_done_i(phy_cal_done),
        .req_rd_i  (phy_rd_pend),
        .req_wr_i  (phy_wr_pend),
        .req_addr_i(phy_req_addr),
        .ctl_o     (ctl),
        .addr_o    (cmd_addr),
        .bank_o    (cmd_bank),
        .rd_fire_o (rd_fire),
        .wr_fire_o (wr_fire),
        .ack_rd_o  (ack_rd),
        .ack_wr_o  (ack_wr),
        .done_o    (done)
    );

    calreq_en_delay #(.DELAY(RD_DELAY), .LEN(RD_LEN)) u_rd_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .fire_i(rd_fire),
        .en_o  (rddata_en)
    );

    calreq_en_delay #(.DELAY(WR_DELAY), .LEN(WR_LEN)) u_wr_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .fire_i(wr_fire),
        .en_o  (wrdata_en)
    );

    assign cmd_cs_n  = ctl.cs_n;
    assign cmd_ras_n = ctl.ras_n;
    assign cmd_cas_n = ctl.cas_n;
    assign cmd_we_n  = ctl.we_n;

endmodule

// File: rtl/calreq_servicer_chk.sv
module calreq_servicer_chk
    import calreq_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_cs_n,
    input logic              cmd_ras_n,
    input logic              cmd_cas_n,
    input logic              cmd_we_n,
    input logic [ROW_W-1:0]  cmd_addr,
    input logic [BANK_W-1:0] cmd_bank,
    input logic              ack_rd,
    input logic              ack_wr,
    input logic              done
);
    logic col_cmd, rd_cmd, wr_cmd, pre_cmd;
    assign col_cmd = !cmd_cs_n && cmd_ras_n && !cmd_cas_n;
    assign rd_cmd  = col_cmd && cmd_we_n;
    assign wr_cmd  = col_cmd && !cmd_we_n;
    assign pre_cmd = !cmd_cs_n && !cmd_ras_n && cmd_cas_n && !cmd_we_n;

    // R13
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_cs_n |-> (cmd_ras_n && cmd_cas_n && cmd_we_n && cmd_addr == '0 && cmd_bank == '0));

    // R4
    bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_cs_n |-> cmd_bank == '0);

    // R4
    col_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_cmd |-> cmd_addr[1:0] == 2'b00);

    // R9
    ack_after_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd || ack_wr) |-> $past(col_cmd));

    // R8
    dual_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && ack_wr) |-> ($past(wr_cmd) && $past(rd_cmd, 2)));

    // R11
    done_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(pre_cmd && cmd_addr[PRECH_ALL_BIT]));

endmodule

bind calreq_servicer calreq_servicer_chk #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_cs_n (cmd_cs_n),
    .cmd_ras_n(cmd_ras_n),
    .cmd_cas_n(cmd_cas_n),
    .cmd_we_n (cmd_we_n),
    .cmd_addr (cmd_addr),
    .cmd_bank (cmd_bank),
    .ack_rd   (ack_rd),
    .ack_wr   (ack_wr),
    .done     (done)
);

// File: tb/calreq_servicer_bench.sv
`timescale 1ns/1ps
module calreq_servicer_bench;
    localparam int REQ_AW = 8;
    localparam int ROW_W  = 13;
    localparam int BANK_W = 2;
    localparam int PAUSE  = 20;
    localparam int RD_DLY = 7;
    localparam int WR_DLY = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, phy_cal_done = 1'b0, phy_rd_pend = 1'b0, phy_wr_pend = 1'b0;
    logic [REQ_AW-1:0] phy_req_addr = '0;
    logic ack_rd, ack_wr, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
    logic [ROW_W-1:0] cmd_addr;
    logic [BANK_W-1:0] cmd_bank;
    logic rddata_en, wrdata_en, done;

    always #10 clk = ~clk;

    calreq_servicer u_calreq_servicer (
        .clk(clk), .rst_n(rst_n), .start(start), .phy_cal_done(phy_cal_done),
        .phy_rd_pend(phy_rd_pend), .phy_wr_pend(phy_wr_pend), .phy_req_addr(phy_req_addr),
        .ack_rd(ack_rd), .ack_wr(ack_wr), .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n),
        .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n), .cmd_addr(cmd_addr), .cmd_bank(cmd_bank),
        .rddata_en(rddata_en), .wrdata_en(wrdata_en), .done(done)
    );

    int checks = 0, failures = 0;
    int cyc = 0, n_cmd = 0, n_ack = 0;
    int act_cyc = -1, act_addr = -1, rd_cyc = -1, rd_addr = -1, wr_cyc = -1, wr_addr = -1;
    int pre_cyc = -1, pre_addr = -1, ack_cyc = -1, ack_bits = 0, done_rise = -1;
    int rd_due = -1, wr_due = -1;
    logic done_prev = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // monitor: records every command and checks enable timing each cycle
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (cmd_cs_n) begin
                if (!(cmd_ras_n && cmd_cas_n && cmd_we_n) || cmd_addr != '0 || cmd_bank != '0)
                    chk("R13 idle bus", {cmd_ras_n, cmd_cas_n, cmd_we_n}, 7);
            end else begin
                n_cmd++;
                if (cmd_bank != '0) chk("R4 bank", int'(cmd_bank), 0);
                case ({cmd_ras_n, cmd_cas_n, cmd_we_n})
                    3'b011: begin act_cyc = cyc; act_addr = int'(cmd_addr); end
                    3'b101: begin rd_cyc = cyc; rd_addr = int'(cmd_addr); rd_due = cyc + RD_DLY; end
                    3'b100: begin wr_cyc = cyc; wr_addr = int'(cmd_addr); wr_due = cyc + WR_DLY; end
                    3'b010: begin pre_cyc = cyc; pre_addr = int'(cmd_addr); end
                    default: chk("R13 command code", {cmd_ras_n, cmd_cas_n, cmd_we_n}, 0);
                endcase
            end
            if (rddata_en || cyc == rd_due) chk("R6 rddata_en", int'(rddata_en), int'(cyc == rd_due));
            if (wrdata_en || cyc == wr_due) chk("R7 wrdata_en", int'(wrdata_en), int'(cyc == wr_due));
            if (ack_rd || ack_wr) begin
                n_ack++;
                ack_cyc = cyc;
                ack_bits = int'({ack_rd, ack_wr});
            end
            if (done && !done_prev) done_rise = cyc;
            done_prev = done;
        end
    end

    // the bench plays the PHY: present a request now, wait for the acknowledge, drop the flags
    task automatic service(input bit rd, input bit wr, input int a, input int base);
        int n0, a0, t;
        n0 = n_cmd;
        a0 = n_ack;
        phy_rd_pend = rd;
        phy_wr_pend = wr;
        phy_req_addr = a[REQ_AW-1:0];
        t = 0;
        do begin
            step();
            t++;
        end while (n_ack == a0 && t < 200);
        phy_rd_pend = 1'b0;
        phy_wr_pend = 1'b0;
        chk("R9 acknowledge seen", n_ack - a0, 1);
        if (rd) begin
            chk("R3 read cycle", rd_cyc, base);
            chk("R4 read column address", rd_addr, a * 4);
        end
        if (wr) begin
            chk("R5 write cycle", wr_cyc, base + (rd ? 1 : 0));
            chk("R5 write column address", wr_addr, a * 4);
        end
        if (rd && wr) chk("R8 write right after read", wr_cyc - rd_cyc, 1);
        chk("R9 ack cycle", ack_cyc, base + ((rd && wr) ? 2 : 1));
        chk("R9 ack bits", ack_bits, int'({rd, wr}));
        chk("R3 one command per request", n_cmd - n0, int'(rd) + int'(wr));
    endtask

    initial begin
        int ref_c, n0, a0, rdc0, s;
        repeat (4) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 strobes", {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}, 15);
        chk("R1 address", int'(cmd_addr), 0);
        chk("R1 enables", {rddata_en, wrdata_en}, 0);
        chk("R1 acks and done", {ack_rd, ack_wr, done}, 0);
        repeat (3) step();
        chk("R1 no command while start low", n_cmd, 0);

        // R2 activate
        start = 1'b1;
        s = cyc;
        step();
        chk("R2 activate cycle", act_cyc, s + 1);
        chk("R2 activate address", act_addr, 0);
        chk("R2 single command", n_cmd, 1);

        // sweep all addresses, rotating read-only, write-only, both
        for (int a = 0; a < (1 << REQ_AW); a++) begin
            int p;
            p = a % 3;
            service(p != 1, p != 0, a, cyc + PAUSE + 1);
        end

        // R10 empty sample
        ref_c = cyc;
        n0 = n_cmd;
        a0 = n_ack;
        repeat (25) step();
        chk("R10 no command on empty sample", n_cmd - n0, 0);
        chk("R10 no ack on empty sample", n_ack - a0, 0);
        service(1'b1, 1'b0, 5, ref_c + 2 * (PAUSE + 1));

        // R11 calibration done with a read still pending
        ref_c = cyc;
        n0 = n_cmd;
        a0 = n_ack;
        rdc0 = rd_cyc;
        phy_cal_done = 1'b1;
        phy_rd_pend = 1'b1;
        phy_req_addr = 8'd9;
        repeat (PAUSE + 3) step();
        chk("R11 precharge cycle", pre_cyc, ref_c + PAUSE + 1);
        chk("R11 precharge address", pre_addr, 1024);
        chk("R11 done rise cycle", done_rise, ref_c + PAUSE + 2);
        chk("R11 only the precharge", n_cmd - n0, 1);
        chk("R11 pending read ignored", rd_cyc, rdc0);
        chk("R11 no ack", n_ack - a0, 0);
        phy_rd_pend = 1'b0;
        repeat (3) step();
        chk("R12 done held", int'(done), 1);

        // R12 release and restart
        start = 1'b0;
        step();
        chk("R12 done falls", int'(done), 0);
        phy_cal_done = 1'b0;
        repeat (2) step();
        start = 1'b1;
        s = cyc;
        step();
        chk("R12 restart activate", act_cyc, s + 1);
        service(1'b1, 1'b1, 255, cyc + PAUSE + 1);
        repeat (10) step();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule